// File: doc/BRIEF.md
# Link Qualification and Latched Status Monitor

This block decides whether a receive link is usable. It watches two plain inputs: a receive-signal-detect flag and a clock-recovery lock flag. A receive-channel error exists whenever the signal is absent or lock is missing. That error is a link fault. A fault drops link status at once, and the link comes back only after both inputs have stayed good for a programmable number of clock edges.

Status is read through a small register port. The port has a one-bit word select, a read strobe and a 16-bit data output. Two status words are offered. The standard word holds a latching-low copy of link status: a fault clears it, and it stays clear until that word is read. The detailed word holds a live copy of link status and a latching-high lock-error bit. Each latched bit is cleared by a read of its own word: on the clock edge that ends the strobe, it reloads the live condition of that cycle. A fault present during the read therefore wins over the clear.

The block carries no data stream, so it has no valid/ready handshake and no back-pressure. Every pin is a plain level or strobe. The read data is combinational from the word select and the current latched state, so it is valid during the strobe cycle.

Top module: `lnk_watch_top`

## Requirements
- R1: After reset, the standard word (select 0) and the detailed word (select 1) both read 0x0000.
- R2: Detailed-word bit 0 (live link) reads 1 only once signal detect and lock have both been high across QUAL_CYCLES consecutive rising clock edges. One edge fewer still reads 0.
- R3: A receive-channel error clears detailed bit 0 in the same cycle, without waiting for a clock edge. The error is signal detect low or lock low. Qualification then restarts from zero.
- R4: Detailed-word bit 9 (lock error) becomes 1 on the first clock edge on which lock is low. It stays 1 after lock returns until the detailed word is read.
- R5: A read of the detailed word makes bit 9 reload, on that edge, the live lock-error condition: 0 if lock is high, 1 if it is still low.
- R6: Standard-word bit 2 (link, latching low) becomes 0 on the clock edge of a fault. It stays 0 even after the link requalifies, until the standard word is read. That read makes it reload the live link state.
- R7: When a fault is present in the same cycle as a read of the standard word, the bit reloads 0 and the fault is not lost.
- R8: A read of one word leaves the latched bit of the other word unchanged.
- R9: All bits other than bit 2 of the standard word, and bits 0 and 9 of the detailed word, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_det_i | input | 1 | Receive signal present |
| pll_lock_i | input | 1 | Clock recovery in lock |
| rd_sel_i | input | 1 | Word select: 0 standard, 1 detailed |
| rd_stb_i | input | 1 | Read strobe; clears the selected word's latched bit on the edge |
| rd_data_o | output | 16 | Selected status word |

## Verification
The bench builds the block with QUAL_CYCLES set to 4. This keeps qualification short enough to cross the boundary many times: one edge short, exactly reached, and restarted after each fault. With this value, a fault, requalification and re-reads fit in a few cycles. That lets the bench show a latched-low bit staying low after the live link has returned, and show a fault that lands on the read cycle.

// File: rtl/lnk_watch_pkg.sv
package lnk_watch_pkg;
  localparam int DATA_W = 16;

  typedef enum logic {
    SEL_STD = 1'b0,
    SEL_DET = 1'b1
  } word_sel_e;

  localparam int STD_LINK_POS = 2;
  localparam int DET_LINK_POS = 0;
  localparam int DET_LKERR_POS = 9;
endpackage

// File: rtl/lnk_qualifier.sv
module lnk_qualifier #(
  parameter int QUAL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_det_i,
  input  logic pll_lock_i,
  output logic link_up_o,
  output logic rx_err_o,
  output logic lock_err_o
);
  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] QMAX = CNT_W'(QUAL_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             good;

  assign good       = sig_det_i & pll_lock_i;
  assign lock_err_o = ~pll_lock_i;
  assign rx_err_o   = ~sig_det_i | lock_err_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!good)      cnt_q <= '0;
    else if (cnt_q != QMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign link_up_o = good && (cnt_q == QMAX);

  // R2: link can only appear after a cycle in which both inputs were good
  a_r2_rise_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up_o) |-> $past(sig_det_i && pll_lock_i));
  // R3: an error cycle leaves the counter restarted
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |=> !link_up_o || (QUAL_CYCLES == 1));
endmodule

// File: rtl/lnk_sticky_bit.sv
module lnk_sticky_bit #(
  parameter bit LATCH_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic live_i,
  output logic q_o
);
  logic nxt;

  generate
    if (LATCH_HIGH) begin : g_hi
      assign nxt = clr_i ? live_i : (q_o | live_i);
      // R4: a set bit holds until cleared by a read
      a_r4_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && q_o) |=> q_o);
    end else begin : g_lo
      assign nxt = clr_i ? live_i : (q_o & live_i);
      // R6: a cleared bit holds until cleared by a read
      a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !q_o) |=> !q_o);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= nxt;
  end
endmodule

// File: rtl/lnk_reg_view.sv
module lnk_reg_view
  import lnk_watch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel_i,
  input  logic              rd_stb_i,
  input  logic              std_link_i,
  input  logic              det_link_i,
  input  logic              det_lkerr_i,
  output logic              clr_std_o,
  output logic              clr_det_o,
  output logic [DATA_W-1:0] rd_data_o
);
  word_sel_e sel;
  assign sel = word_sel_e'(rd_sel_i);

  assign clr_std_o = rd_stb_i && (sel == SEL_STD);
  assign clr_det_o = rd_stb_i && (sel == SEL_DET);

  always_comb begin
    rd_data_o = '0;
    if (sel == SEL_STD) begin
      rd_data_o[STD_LINK_POS] = std_link_i;
    end else begin
      rd_data_o[DET_LINK_POS]  = det_link_i;
      rd_data_o[DET_LKERR_POS] = det_lkerr_i;
    end
  end

  // R9: at most the defined fields are ever set
  a_r9_fields_only: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_data_o) <= 2);
endmodule

// File: rtl/lnk_watch_top.sv
module lnk_watch_top
  import lnk_watch_pkg::*;
#(
  parameter int QUAL_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_det_i,
  input  logic              pll_lock_i,
  input  logic              rd_sel_i,
  input  logic              rd_stb_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic link_live, rx_err, lock_live;
  logic clr_std, clr_det;
  logic std_link_q, lkerr_q;

  lnk_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst_n(rst_n), .sig_det_i(sig_det_i), .pll_lock_i(pll_lock_i),
    .link_up_o(link_live), .rx_err_o(rx_err), .lock_err_o(lock_live)
  );

  lnk_sticky_bit #(.LATCH_HIGH(1'b0)) u_std_link (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_std), .live_i(link_live), .q_o(std_link_q)
  );

  lnk_sticky_bit #(.LATCH_HIGH(1'b1)) u_lkerr (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_det), .live_i(lock_live), .q_o(lkerr_q)
  );

  lnk_reg_view u_view (
    .clk(clk), .rst_n(rst_n), .rd_sel_i(rd_sel_i), .rd_stb_i(rd_stb_i),
    .std_link_i(std_link_q), .det_link_i(link_live), .det_lkerr_i(lkerr_q),
    .clr_std_o(clr_std), .clr_det_o(clr_det), .rd_data_o(rd_data_o)
  );

  // R6/R7: a fault, read or not, leaves the latching-low copy clear
  a_r7_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> !std_link_q);
  // R4: lock loss is captured on the next edge
  a_r4_lock_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_lock_i |=> lkerr_q);
  // R8: a standard-word read never clears the lock-error latch
  a_r8_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_std && lkerr_q) |=> lkerr_q);
endmodule

// File: tb/lnk_watch_tb.sv
module lnk_watch_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_det = 1'b0;
  logic pll_lock = 1'b1;
  logic rd_sel = 1'b0;
  logic rd_stb = 1'b0;
  logic [15:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lnk_watch_top #(.QUAL_CYCLES(QC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sig_det_i(sig_det), .pll_lock_i(pll_lock),
    .rd_sel_i(rd_sel), .rd_stb_i(rd_stb), .rd_data_o(rd_data)
  );

  // driver: queue the expectation and strobe for one cycle
  task automatic rd(input logic sel, input logic [15:0] exp, input string tag);
    rd_sel = sel;
    rd_stb = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compare a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rd_stb && exp_q.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL %s: read 0x%04h expected 0x%04h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    rd(1'b0, 16'h0000, "R1 standard word after reset");
    rd(1'b1, 16'h0000, "R1 detailed word after reset");

    sig_det = 1'b1; pll_lock = 1'b1;
    wait_cyc(QC - 1);
    rd(1'b1, 16'h0000, "R2 one edge short of qualification");
    rd(1'b1, 16'h0001, "R2 qualified link");
    rd(1'b0, 16'h0000, "R6 latching-low bit from reset still clear");
    rd(1'b0, 16'h0004, "R6 reload after read");

    sig_det = 1'b0;
    rd(1'b1, 16'h0000, "R3 signal loss drops live link at once");
    sig_det = 1'b1;
    wait_cyc(QC - 1);
    rd(1'b1, 16'h0000, "R3 qualification restarted");
    rd(1'b1, 16'h0001, "R3 requalified");
    rd(1'b0, 16'h0000, "R6 stays low after link returns");
    rd(1'b0, 16'h0004, "R6 reload after read");

    pll_lock = 1'b0;
    wait_cyc(1);
    pll_lock = 1'b1;
    wait_cyc(QC + 1);
    rd(1'b0, 16'h0000, "R8 standard word after lock fault");
    rd(1'b1, 16'h0201, "R4 R8 lock error held after lock returned");
    rd(1'b1, 16'h0001, "R5 reload with lock present");

    pll_lock = 1'b0;
    wait_cyc(1);
    rd(1'b1, 16'h0200, "R5 lock error seen");
    rd(1'b1, 16'h0200, "R5 reload while still unlocked");
    pll_lock = 1'b1;
    rd(1'b1, 16'h0200, "R4 latched after lock return");
    rd(1'b1, 16'h0000, "R5 cleared after read with lock present");
    wait_cyc(QC);
    rd(1'b1, 16'h0001, "R2 requalified after lock fault");

    rd(1'b0, 16'h0000, "R6 low from lock fault");
    rd(1'b0, 16'h0004, "R6 reload");
    sig_det = 1'b0;
    rd(1'b0, 16'h0004, "R7 latched value shown during fault read");
    sig_det = 1'b1;
    wait_cyc(QC);
    rd(1'b1, 16'h0001, "R7 link live again");
    rd(1'b0, 16'h0000, "R7 fault in read cycle not lost");
    rd(1'b0, 16'h0004, "R9 only bit 2 set in standard word");

    wait_cyc(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule